// File: doc/BRIEF.md
# Security-Banked System Handler Priority Registers

This block holds the 8-bit priority values for the configurable system exceptions of a microcontroller interrupt controller that has a security extension. Software reaches the values through a 12-byte window of three 32-bit words. Byte, halfword and word accesses are all allowed. Every access carries a secure or non-secure attribute.

Each byte lane of an access is resolved on its own. A lane goes to the secure copy of a handler's priority, to the non-secure (or only) copy, or is read-as-zero/write-ignored. Which of the three applies depends on the handler, on the attribute and on a control input that hands the bus-fault handler to non-secure code. Both banks are presented as flat vectors to the pending and arbitration logic. After every write into the window, a one-cycle pulse tells that logic to re-evaluate.

Top module: `shpri_bank_regs`

## Requirements
- R1: After reset every priority field in both banks is zero, `rdata_o` is zero and `upd_o` is low.
- R2: The window covers byte offsets 0xD18 to 0xD23. The byte at offset A belongs to exception number A-0xD14. Lane i of an access targets offset `addr_i`+i and uses data bits [8i+7:8i]. Only lanes with i < `size_i` (1, 2 or 4) that stay inside the window take part. An access whose start is outside the window changes nothing.
- R3: Exceptions 4, 6, 11, 14 and 15 are banked. A secure access (`sec_i`=1) uses the secure copy, and a non-secure access uses the non-secure copy.
- R4: Exception 5 has a single copy. A non-secure access to it is read-as-zero/write-ignored while `bf_ns_own_i`=0. Otherwise it reaches the single copy.
- R5: Exception 7 has a single copy. A secure access reaches it, and a non-secure access is read-as-zero/write-ignored.
- R6: Exception 12 has a single copy that both security states read and write.
- R7: The fields for exceptions 8, 9, 10 and 13 always read zero and ignore writes.
- R8: A read (`req_i`=1, `we_i`=0) returns its data on `rdata_o` in the following cycle. Ignored lanes, lanes beyond the size and lanes outside the window read zero. `rdata_o` is zero in any cycle that follows no read.
- R9: `upd_o` is high for exactly the cycle after any write that starts inside the window, even when every lane was ignored. It is low otherwise.
- R10: Byte n of `prio_ns_o` is the non-secure or single copy of exception n. Byte n of `prio_s_o` is the secure copy for banked exceptions and zero for all others. A write becomes visible on these vectors in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| wdata_i | input | 32 | Write data, lane i in bits [8i+7:8i] |
| sec_i | input | 1 | Access is secure |
| bf_ns_own_i | input | 1 | Non-secure code owns the bus-fault priority |
| rdata_o | output | 32 | Read data, one cycle after the request |
| upd_o | output | 1 | Pulse after a write into the window |
| prio_ns_o | output | 128 | Non-secure/single-copy priorities, byte n = exception n |
| prio_s_o | output | 128 | Secure-bank priorities, byte n = exception n |

## Verification
Word writes and reads are issued to each of the three words first with the secure attribute and then with the non-secure one. The same write data must then appear in different banks, which separates bank selection from plain storage. The bus-fault lane is tried with the ownership input at both values, and non-secure writes to the secure-fault and reserved lanes are checked for no effect. Halfword and byte accesses, an access that runs past the window end and an access that starts outside the window show whether lane gating follows the size and the window bounds. An all-ignored write shows that the update pulse does not depend on any lane being stored.

// File: rtl/shpri_bank_regs.sv
module shpri_bank_regs #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [31:0]       wdata_i,
  input  logic              sec_i,
  input  logic              bf_ns_own_i,
  output logic [31:0]       rdata_o,
  output logic              upd_o,
  output logic [127:0]      prio_ns_o,
  output logic [127:0]      prio_s_o
);
  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(12'hD18);
  localparam logic [ADDR_W-1:0] WIN_HI  = ADDR_W'(12'hD23);
  localparam logic [ADDR_W-1:0] EXC_OFS = ADDR_W'(12'hD14);
  localparam logic [1:0] RT_NONE = 2'd0;
  localparam logic [1:0] RT_NS   = 2'd1;
  localparam logic [1:0] RT_S    = 2'd2;

  function automatic logic [1:0] route(input logic [3:0] exc, input logic sec, input logic bf_own);
    case (exc)
      4'd4, 4'd6, 4'd11, 4'd14, 4'd15: route = sec ? RT_S : RT_NS;
      4'd5:  route = (!sec && !bf_own) ? RT_NONE : RT_NS;
      4'd7:  route = sec ? RT_NS : RT_NONE;
      4'd12: route = RT_NS;
      default: route = RT_NONE;
    endcase
  endfunction

  logic [7:0] ns_q [16];
  logic [7:0] s_q  [16];
  logic [3:0] lane_on;
  logic [3:0] lane_exc [4];
  logic [1:0] lane_rt  [4];
  logic [31:0] rd_val;
  logic hit;

  assign hit = req_i && (addr_i >= WIN_LO) && (addr_i <= WIN_HI);

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < 4; i++) begin
      logic [ADDR_W-1:0] off;
      off         = addr_i + ADDR_W'(i);
      lane_exc[i] = 4'(off - EXC_OFS);
      lane_on[i]  = hit && (3'(i) < size_i) && (off <= WIN_HI);
      lane_rt[i]  = lane_on[i] ? route(lane_exc[i], sec_i, bf_ns_own_i) : RT_NONE;
      if (lane_rt[i] == RT_NS)     rd_val[8*i +: 8] = ns_q[lane_exc[i]];
      else if (lane_rt[i] == RT_S) rd_val[8*i +: 8] = s_q[lane_exc[i]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < 16; e++) begin
        ns_q[e] <= '0;
        s_q[e]  <= '0;
      end
      rdata_o <= '0;
      upd_o   <= 1'b0;
    end else begin
      rdata_o <= (hit && !we_i) ? rd_val : '0;
      upd_o   <= hit && we_i;
      if (we_i) begin
        for (int i = 0; i < 4; i++) begin
          if (lane_rt[i] == RT_NS) ns_q[lane_exc[i]] <= wdata_i[8*i +: 8];
          if (lane_rt[i] == RT_S)  s_q[lane_exc[i]]  <= wdata_i[8*i +: 8];
        end
      end
    end
  end

  for (genvar e = 0; e < 16; e++) begin : g_out
    assign prio_ns_o[8*e +: 8] = ns_q[e];
    assign prio_s_o[8*e +: 8]  = s_q[e];
  end
endmodule

// File: rtl/shpri_bank_regs_sva.sv
module shpri_bank_regs_sva #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              sec_i,
  input logic [31:0]       wdata_i,
  input logic [2:0]        size_i,
  input logic [31:0]       rdata_o,
  input logic              upd_o,
  input logic [127:0]      prio_ns_o,
  input logic [127:0]      prio_s_o
);
  logic in_win;
  assign in_win = (addr_i >= ADDR_W'(12'hD18)) && (addr_i <= ADDR_W'(12'hD23));

  assert_upd_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && in_win) |=> upd_o);

  assert_no_upd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && we_i) |=> !upd_o);

  assert_idle_rdata_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (rdata_o == 32'h0));

  assert_secfault_ns_wi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && !sec_i && addr_i == ADDR_W'(12'hD1B)) |=> $stable(prio_ns_o[63:56]));

  assert_bank_s_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && sec_i && addr_i == ADDR_W'(12'hD18) && size_i != 3'd0)
      |=> (prio_s_o[39:32] == $past(wdata_i[7:0])));

  assert_resv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_ns_o[71:64] == 8'h0) && (prio_ns_o[87:72] == 16'h0) && (prio_ns_o[111:104] == 8'h0)
      && (prio_s_o[111:104] == 8'h0));
endmodule

bind shpri_bank_regs shpri_bank_regs_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .sec_i(sec_i), .wdata_i(wdata_i), .size_i(size_i), .rdata_o(rdata_o),
  .upd_o(upd_o), .prio_ns_o(prio_ns_o), .prio_s_o(prio_s_o)
);

// File: tb/shpri_bank_regs_tb_top.sv
`timescale 1ns/1ps
module shpri_bank_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, sec = 1'b0, bf = 1'b0;
  logic [11:0] addr = '0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic upd;
  logic [127:0] pns, ps;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_ns [16];
  logic [7:0] m_s  [16];

  always #5 clk = ~clk;

  shpri_bank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .sec_i(sec), .bf_ns_own_i(bf), .rdata_o(rdata), .upd_o(upd),
    .prio_ns_o(pns), .prio_s_o(ps)
  );

  // 0 = ignored, 1 = non-secure/single copy, 2 = secure copy
  function automatic int exp_route(int e, bit s, bit own);
    if (e == 4 || e == 6 || e == 11 || e == 14 || e == 15) return s ? 2 : 1;
    if (e == 5) return (!s && !own) ? 0 : 1;
    if (e == 7) return s ? 1 : 0;
    if (e == 12) return 1;
    return 0;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_vectors(string tag);
    logic [127:0] en, es;
    for (int e = 0; e < 16; e++) begin
      en[8*e +: 8] = m_ns[e];
      es[8*e +: 8] = m_s[e];
    end
    check({tag, " prio_ns"}, pns, en);
    check({tag, " prio_s"}, ps, es);
  endtask

  task automatic access(string tag, logic [11:0] a, bit w, logic [2:0] sz, logic [31:0] d, bit s);
    logic [31:0] exp_rd = '0;
    bit in_win = (a >= 12'hD18) && (a <= 12'hD23);
    for (int i = 0; i < 4; i++) begin
      int off = int'(a) + i;
      int e = off - 'hD14;
      int rt;
      if (!in_win || i >= int'(sz) || off > 'hD23) continue;
      rt = exp_route(e, s, bf);
      if (!w) begin
        if (rt == 1) exp_rd[8*i +: 8] = m_ns[e];
        if (rt == 2) exp_rd[8*i +: 8] = m_s[e];
      end else begin
        if (rt == 1) m_ns[e] = d[8*i +: 8];
        if (rt == 2) m_s[e]  = d[8*i +: 8];
      end
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d; sec = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check({tag, " rdata"}, {96'h0, rdata}, {96'h0, exp_rd});
    check({tag, " upd"}, {127'h0, upd}, {127'h0, (w && in_win)});
    check_vectors(tag);
  endtask

  task automatic t_reset();
    for (int e = 0; e < 16; e++) begin m_ns[e] = '0; m_s[e] = '0; end
    check("R1 rdata", {96'h0, rdata}, 128'h0);
    check("R1 upd", {127'h0, upd}, 128'h0);
    check_vectors("R1");
  endtask

  task automatic t_banked();
    access("R3 sec write w0", 12'hD18, 1, 4, 32'h44332211, 1);
    access("R3 ns write w0", 12'hD18, 1, 4, 32'hA4A3A2A1, 0);
    access("R3 sec read w0", 12'hD18, 0, 4, 0, 1);
    access("R3 ns read w0", 12'hD18, 0, 4, 0, 0);
  endtask

  task automatic t_busfault();
    bf = 1'b1;
    access("R4 ns write owned", 12'hD19, 1, 1, 32'h0000005B, 0);
    access("R4 ns read owned", 12'hD18, 0, 4, 0, 0);
    bf = 1'b0;
    access("R4 ns read unowned", 12'hD19, 0, 1, 0, 0);
    access("R4 sec read", 12'hD19, 0, 1, 0, 1);
  endtask

  task automatic t_secfault();
    access("R5 ns write", 12'hD1B, 1, 1, 32'h000000EE, 0);
    access("R5 ns read", 12'hD1B, 0, 1, 0, 0);
    access("R5 sec read", 12'hD1B, 0, 1, 0, 1);
  endtask

  task automatic t_reserved();
    access("R7 sec write w1", 12'hD1C, 1, 4, 32'hFFFFFFFF, 1);
    access("R7 ns write w1", 12'hD1C, 1, 4, 32'h7E7D7C7B, 0);
    access("R7 sec read w1", 12'hD1C, 0, 4, 0, 1);
    access("R9 all-ignored write", 12'hD1C, 1, 1, 32'h00000055, 1);
  endtask

  task automatic t_word2();
    access("R6 sec write w2", 12'hD20, 1, 4, 32'h2F2E2D2C, 1);
    access("R6 ns write w2", 12'hD20, 1, 4, 32'h1F1E1D1C, 0);
    access("R6 ns read w2", 12'hD20, 0, 4, 0, 0);
    access("R6 sec read w2", 12'hD20, 0, 4, 0, 1);
  endtask

  task automatic t_sizes();
    access("R2 half write", 12'hD22, 1, 2, 32'hFFFF6655, 0);
    access("R2 word past end", 12'hD23, 1, 4, 32'h33221177, 1);
    access("R2 byte read", 12'hD19, 0, 1, 0, 1);
    access("R2 half read", 12'hD22, 0, 2, 0, 1);
    access("R2 outside write", 12'hD24, 1, 4, 32'h12345678, 1);
    access("R2 below write", 12'hD14, 1, 4, 32'h12345678, 1);
    access("R8 outside read", 12'hD10, 0, 4, 0, 1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R8 idle rdata", {96'h0, rdata}, 128'h0);
    check("R9 idle upd", {127'h0, upd}, 128'h0);
    check_vectors("R10 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_banked();
    t_busfault();
    t_secfault();
    t_reserved();
    t_word2();
    t_sizes();
    t_idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule